// File: doc/BRIEF.md
# Loopback Test Register Bank

This block is a small bank of memory-mapped registers. Host software uses it to check that its register accesses work, that interrupts arrive on the vector it asks for, and that DMA setup values can be programmed. It sits on a plain 32-bit register bus with an address, a write enable with write data, and a read enable with read data. Read data comes back one cycle after the read enable.

The two scratch registers are 32 and 64 bits wide. Each reads back twice the last value written to it, so a reader can tell a real register from a bus that echoes the written value. A 64-bit register is written as two 32-bit halves, lower half first. The lower half waits in a staging latch until the upper half arrives, so a reader never sees a mix of an old half and a new half.

A write to the interrupt test register raises one interrupt. The written value is taken as a single vector number, not as a bitmask. A value that does not fit in a vector number fires nothing and sets a sticky error flag. The DMA address, size and control registers keep whatever is written to them. No transfer is performed.

Top module: `loopback_test_bank`

## Requirements
- R1: After reset, every register reads as zero, `busRdData` is zero, `irqFire` is low and `vecErr` is low.
- R2: A read at byte offset 0x10 returns twice the last value written to offset 0x10, truncated to 32 bits.
- R3: The 64-bit scratch register is read at two offsets. Offset 0x18 returns bits 31:0 of twice its committed value, and offset 0x1C returns bits 63:32, all truncated to 64 bits.
- R4: A write to offset 0x18 only stages a lower half, and reads of the 64-bit scratch register stay unchanged. A later write to offset 0x1C commits {upper half written, staged lower half} as the new value.
- R5: Writing a value n below 256 to offset 0x20 drives `irqFire` high, with `irqVec` equal to n, in the single cycle after the write. `irqFire` falls again unless the next cycle also writes a valid vector.
- R6: Writing a value of 256 or more to offset 0x20 leaves `irqFire` low and sets `vecErr`. `vecErr` stays high until reset.
- R7: The DMA address is a 64-bit register. Its lower half is written at 0x28 and its upper half at 0x2C, staged and committed the same way as in R4. Reads return the committed halves unchanged.
- R8: The DMA size register at 0x30, the DMA control register at 0x34 and the interrupt test register at 0x20 read back exactly the last value written to them.
- R9: A read of any offset not named in R2 to R8 returns zero, and this includes offsets that are not multiples of 4. A write to such an offset changes no register.
- R10: `busRdData` shows the selected value in the cycle after `busRdEn` is high. In any cycle that follows a cycle without a read, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered |
| irqFire | output | 1 | One-cycle interrupt request |
| irqVec | output | 8 | Vector number of the request |
| vecErr | output | 1 | Sticky out-of-range vector flag |

## Verification
The assertions assume that the bus never raises write and read in the same cycle. They also assume that a lower-half write and its upper-half write to the same 64-bit register are not interleaved with writes to the other halves of that register. The one-hot check on the write strobes assumes the address decode sees a single address per cycle. The bench drives each access as its own transaction, starting on a falling edge and holding for one full cycle. Every lower-half write is followed directly by its upper-half write, so the stimulus stays inside these assumptions.

// File: rtl/lbt_pkg.sv
`timescale 1ns/1ps
package lbt_pkg;

  // Byte offsets seen by host software; decoded by the control block.
  localparam int OFF_SCR32   = 'h10;
  localparam int OFF_SCR64LO = 'h18;
  localparam int OFF_SCR64HI = 'h1C;
  localparam int OFF_IRQ     = 'h20;
  localparam int OFF_DMALO   = 'h28;
  localparam int OFF_DMAHI   = 'h2C;
  localparam int OFF_SIZE    = 'h30;
  localparam int OFF_CTL     = 'h34;

  // Write strobes from control to datapath, at most one set per cycle.
  typedef struct packed {
    logic scr32;
    logic scrLo;
    logic scrHi;
    logic irq;
    logic dmaLo;
    logic dmaHi;
    logic size;
    logic ctl;
  } wrStrobe_t;

  // Read source selection.
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SCR32,
    SEL_SCR64LO,
    SEL_SCR64HI,
    SEL_IRQ,
    SEL_DMALO,
    SEL_DMAHI,
    SEL_SIZE,
    SEL_CTL
  } rdSel_t;

endpackage

// File: rtl/lbt_pair64.sv
`timescale 1ns/1ps
module lbt_pair64 #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [HALF_W-1:0] wrData,
  output logic [FULL_W-1:0] full
);

  logic [HALF_W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
      full  <= '0;
    end else begin
      if (wrLo) stage <= wrData;
      if (wrHi) full  <= {wrData, stage};
    end
  end

  // R4: a staged lower half alone never alters the committed value
  assert_lo_no_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrHi) |=> $stable(full));

  // R4: upper-half write commits the staged lower half underneath
  assert_hi_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !wrLo) |=> (full[HALF_W-1:0] == $past(stage)) &&
                        (full[FULL_W-1:HALF_W] == $past(wrData)));

endmodule

// File: rtl/lbt_ctrl.sv
`timescale 1ns/1ps
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output wrStrobe_t         wrStb,
  output rdSel_t            rdSel,
  output logic              rdStb,
  output logic              irqFire,
  output logic [VEC_W-1:0]  irqVec,
  output logic              vecErr
);

  rdSel_t hit;
  logic   vecOk;

  always_comb begin
    unique case (addr)
      ADDR_W'(OFF_SCR32):   hit = SEL_SCR32;
      ADDR_W'(OFF_SCR64LO): hit = SEL_SCR64LO;
      ADDR_W'(OFF_SCR64HI): hit = SEL_SCR64HI;
      ADDR_W'(OFF_IRQ):     hit = SEL_IRQ;
      ADDR_W'(OFF_DMALO):   hit = SEL_DMALO;
      ADDR_W'(OFF_DMAHI):   hit = SEL_DMAHI;
      ADDR_W'(OFF_SIZE):    hit = SEL_SIZE;
      ADDR_W'(OFF_CTL):     hit = SEL_CTL;
      default:              hit = SEL_NONE;
    endcase
  end

  always_comb begin
    wrStb       = '0;
    wrStb.scr32 = wrEn && (hit == SEL_SCR32);
    wrStb.scrLo = wrEn && (hit == SEL_SCR64LO);
    wrStb.scrHi = wrEn && (hit == SEL_SCR64HI);
    wrStb.irq   = wrEn && (hit == SEL_IRQ);
    wrStb.dmaLo = wrEn && (hit == SEL_DMALO);
    wrStb.dmaHi = wrEn && (hit == SEL_DMAHI);
    wrStb.size  = wrEn && (hit == SEL_SIZE);
    wrStb.ctl   = wrEn && (hit == SEL_CTL);
  end

  assign rdSel = hit;
  assign rdStb = rdEn;
  assign vecOk = (wrData >> VEC_W) == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFire <= 1'b0;
      irqVec  <= '0;
      vecErr  <= 1'b0;
    end else begin
      irqFire <= wrStb.irq && vecOk;
      if (wrStb.irq && vecOk) irqVec <= wrData[VEC_W-1:0];
      if (wrStb.irq && !vecOk) vecErr <= 1'b1;
    end
  end

  // R5: an in-range vector write yields a request on that vector next cycle
  assert_vec_fire_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_IRQ) && (wrData >> VEC_W) == '0)
      |=> (irqFire && irqVec == $past(wrData[VEC_W-1:0])));

  // R6: an out-of-range vector write fires nothing and flags an error
  assert_bad_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_IRQ) && (wrData >> VEC_W) != '0)
      |=> (!irqFire && vecErr));

  // R6: the error flag never clears outside reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecErr |=> vecErr);

  // R9: no access ever drives more than one register write
  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStb));

endmodule

// File: rtl/lbt_data.sv
`timescale 1ns/1ps
module lbt_data
  import lbt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int N_PAIR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdSel_t            rdSel,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] scr32Q, irqQ, sizeQ, ctlQ;
  logic [N_PAIR-1:0] loStb, hiStb;
  logic [N_PAIR-1:0][WIDE_W-1:0] pairVal;
  logic [WIDE_W-1:0] scr64Dbl;
  logic [DATA_W-1:0] scr32Dbl;
  logic [DATA_W-1:0] muxVal;

  // pair 0: 64-bit scratch, pair 1: DMA address
  assign loStb = {wrStb.dmaLo, wrStb.scrLo};
  assign hiStb = {wrStb.dmaHi, wrStb.scrHi};

  for (genvar g = 0; g < N_PAIR; g++) begin : gPair
    lbt_pair64 #(.HALF_W(DATA_W)) uPair (
      .clk    (clk),
      .rstN   (rstN),
      .wrLo   (loStb[g]),
      .wrHi   (hiStb[g]),
      .wrData (wrData),
      .full   (pairVal[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scr32Q <= '0;
      irqQ   <= '0;
      sizeQ  <= '0;
      ctlQ   <= '0;
    end else begin
      if (wrStb.scr32) scr32Q <= wrData;
      if (wrStb.irq)   irqQ   <= wrData;
      if (wrStb.size)  sizeQ  <= wrData;
      if (wrStb.ctl)   ctlQ   <= wrData;
    end
  end

  assign scr32Dbl = {scr32Q[DATA_W-2:0], 1'b0};
  assign scr64Dbl = {pairVal[0][WIDE_W-2:0], 1'b0};

  always_comb begin
    unique case (rdSel)
      SEL_SCR32:   muxVal = scr32Dbl;
      SEL_SCR64LO: muxVal = scr64Dbl[DATA_W-1:0];
      SEL_SCR64HI: muxVal = scr64Dbl[WIDE_W-1:DATA_W];
      SEL_IRQ:     muxVal = irqQ;
      SEL_DMALO:   muxVal = pairVal[1][DATA_W-1:0];
      SEL_DMAHI:   muxVal = pairVal[1][WIDE_W-1:DATA_W];
      SEL_SIZE:    muxVal = sizeQ;
      SEL_CTL:     muxVal = ctlQ;
      default:     muxVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdStb ? muxVal : '0;
  end

  // R9: reads that miss the map come back as zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdSel == SEL_NONE) |=> (rdData == '0));

  // R10: the read bus idles at zero after a cycle without a read
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> (rdData == '0));

  // R2: the 32-bit scratch readback is always even
  assert_scr32_even_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdSel == SEL_SCR32) |=> (rdData[0] == 1'b0));

endmodule

// File: rtl/loopback_test_bank.sv
`timescale 1ns/1ps
module loopback_test_bank
  import lbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqFire,
  output logic [VEC_W-1:0]  irqVec,
  output logic              vecErr
);

  wrStrobe_t wrStb;
  rdSel_t    rdSel;
  logic      rdStb;

  lbt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (busAddr),
    .wrEn    (busWrEn),
    .wrData  (busWrData),
    .rdEn    (busRdEn),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .rdStb   (rdStb),
    .irqFire (irqFire),
    .irqVec  (irqVec),
    .vecErr  (vecErr)
  );

  lbt_data #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .rdSel  (rdSel),
    .rdStb  (rdStb),
    .wrData (busWrData),
    .rdData (busRdData)
  );

endmodule

// File: tb/test_loopback_test_bank.sv
`timescale 1ns/1ps
module test_loopback_test_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqFire;
  logic [7:0]  irqVec;
  logic        vecErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  loopback_test_bank i_loopback_test_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqFire(irqFire), .irqVec(irqVec), .vecErr(vecErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write: driven on a falling edge, captured at the next rising edge.
  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk); #1;
    d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    doRead(a, v);
    check(v == e, req, v, e);
  endtask

  function automatic bit isMapped(input int a);
    return a == 'h10 || a == 'h18 || a == 'h1C || a == 'h20 ||
           a == 'h28 || a == 'h2C || a == 'h30 || a == 'h34;
  endfunction

  initial begin
    #750000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] wide;
    logic [31:0] pat;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    check(busRdData == 0, "R1 rdData", busRdData, 0);
    check(irqFire == 0, "R1 irqFire", irqFire, 0);
    check(vecErr == 0, "R1 vecErr", vecErr, 0);
    for (int a = 0; a < 256; a += 4)
      if (isMapped(a)) expectRead(8'(a), 32'h0, "R1 reg zero");

    // R2: doubling with truncation, walking ones and corner values
    for (int i = 0; i < 32; i++) begin
      pat = 32'h1 << i;
      doWrite(8'h10, pat);
      expectRead(8'h10, pat << 1, "R2 walk");
    end
    doWrite(8'h10, 32'h7FFFFFFF); expectRead(8'h10, 32'hFFFFFFFE, "R2 max");
    doWrite(8'h10, 32'h80000001); expectRead(8'h10, 32'h00000002, "R2 wrap");

    // R4: lower half alone does not commit
    doWrite(8'h18, 32'h89ABCDEF);
    expectRead(8'h18, 32'h0, "R4 staged lo");
    expectRead(8'h1C, 32'h0, "R4 staged hi");
    doWrite(8'h1C, 32'h81234567);
    wide = {32'h81234567, 32'h89ABCDEF} << 1;
    // R3: halves of the doubled committed value
    expectRead(8'h18, wide[31:0], "R3 lo");
    expectRead(8'h1C, wide[63:32], "R3 hi");
    for (int i = 0; i < 64; i += 7) begin
      wide = 64'h1 << i;
      doWrite(8'h18, wide[31:0]);
      doWrite(8'h1C, wide[63:32]);
      wide = wide << 1;
      expectRead(8'h18, wide[31:0], "R3 sweep lo");
      expectRead(8'h1C, wide[63:32], "R3 sweep hi");
    end
    // R4: re-commit uses the last staged lower half
    doWrite(8'h18, 32'h00000005);
    doWrite(8'h18, 32'h00000009);
    doWrite(8'h1C, 32'h00000000);
    expectRead(8'h18, 32'h00000012, "R4 last staged");

    // R5: every in-range vector
    for (int n = 0; n < 256; n++) begin
      @(negedge clk);
      busAddr = 8'h20; busWrData = 32'(n); busWrEn = 1'b1;
      @(posedge clk); #1;
      check(irqFire == 1'b1, "R5 fire", irqFire, 1);
      check(irqVec == 8'(n), "R5 vec", irqVec, n);
      @(negedge clk);
      busWrEn = 1'b0;
      @(posedge clk); #1;
      check(irqFire == 1'b0, "R5 single cycle", irqFire, 0);
    end
    check(vecErr == 1'b0, "R6 no error for valid", vecErr, 0);
    // R8: interrupt register reads back
    expectRead(8'h20, 32'd255, "R8 irq readback");

    // R6: out of range vectors
    @(negedge clk);
    busAddr = 8'h20; busWrData = 32'd256; busWrEn = 1'b1;
    @(posedge clk); #1;
    check(irqFire == 1'b0, "R6 no fire 256", irqFire, 0);
    check(vecErr == 1'b1, "R6 err set", vecErr, 1);
    @(negedge clk) busWrData = 32'hFFFFFFFF;
    @(posedge clk); #1;
    check(irqFire == 1'b0, "R6 no fire max", irqFire, 0);
    @(negedge clk) busWrData = 32'd7;
    @(posedge clk); #1;
    check(irqFire == 1'b1 && irqVec == 8'd7, "R5 fire after error", {irqFire, irqVec}, {1'b1, 8'd7});
    check(vecErr == 1'b1, "R6 sticky", vecErr, 1);
    @(negedge clk) busWrEn = 1'b0;

    // R7: DMA address
    doWrite(8'h28, 32'hDEADBEEF);
    expectRead(8'h28, 32'h0, "R7 staged");
    doWrite(8'h2C, 32'hCAFEF00D);
    expectRead(8'h28, 32'hDEADBEEF, "R7 lo");
    expectRead(8'h2C, 32'hCAFEF00D, "R7 hi");

    // R8: size and control
    doWrite(8'h30, 32'h00010000); expectRead(8'h30, 32'h00010000, "R8 size");
    doWrite(8'h34, 32'hA5A5A5A5); expectRead(8'h34, 32'hA5A5A5A5, "R8 ctl");

    // R9: unmapped offsets read zero, writes ignored
    for (int a = 0; a < 256; a += 4)
      if (!isMapped(a)) begin
        doWrite(8'(a), 32'hFFFFFFFF);
        expectRead(8'(a), 32'h0, "R9 unmapped");
      end
    doWrite(8'h11, 32'h12345678);
    expectRead(8'h11, 32'h0, "R9 misaligned");
    expectRead(8'h10, 32'h00000002, "R9 scr32 kept");
    expectRead(8'h18, 32'h00000012, "R9 scr64 kept");
    expectRead(8'h28, 32'hDEADBEEF, "R9 dma kept");
    expectRead(8'h30, 32'h00010000, "R9 size kept");
    expectRead(8'h34, 32'hA5A5A5A5, "R9 ctl kept");
    expectRead(8'h20, 32'd7, "R9 irq kept");

    // R10: read data returns to zero after an idle cycle
    doRead(8'h34, v);
    check(v == 32'hA5A5A5A5, "R10 read", v, 32'hA5A5A5A5);
    @(posedge clk); #1;
    check(busRdData == 0, "R10 idle zero", busRdData, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule